// File: doc/BRIEF.md
# Glitch-Free Clock Source Switcher

This block drives one output clock from one of several free-running source clocks and moves it between sources without producing a short pulse. Software running on the output clock writes a select code and a source kind. If the code differs from the source that is running now, a handover begins. The outgoing source stops the output at one of its own falling edges, so the output rests low. The incoming source then counts its own falling edges until it is trusted, and only then gates itself onto the output. A status flag reports when the output frequency can be relied on.

The number of edges the incoming source counts depends on what is being switched. A normal handover counts a short run of edges. A crystal-type target reached from the slow default source (source 0) counts a long oscillator start-up run first. An internal-oscillator target reached from source 0 is gated on after the short run, but the status flag then waits a further settling count of output cycles. A write that arrives while a handover is in progress is held and carried out once the current one finishes.

Top module: `clk_switcher`

## Requirements
- R1: After reset the output follows source 0, no handover is pending and `freqStable` is 0.
- R2: A write (`selWrite` high at a rising output edge) whose `selCode` differs from the running source starts a handover, and `freqStable` is 0 from the next output edge on.
- R3: A write whose `selCode` equals the running source, made while no handover is in progress, changes nothing: the output keeps its source and `freqStable` keeps its value.
- R4: During a handover no two sources are gated onto the output together. The output rests low from a falling edge of the old source for at least `HAND_CYC` periods of the new source, and it never carries a pulse shorter than half the fastest source period.
- R5: When the new source has been gated on, `freqStable` becomes 1 and the output period equals the new source's period. This holds for every case that R6, R7 and R8 do not name.
- R6: `selKind` encodes the target kind: 0 = internal oscillator, 1 = crystal, 2 = external clock or RC. A crystal target reached from source 0 waits `OST_CYC` falling edges of the target before it is gated on.
- R7: A crystal target reached from any source other than 0 waits only `HAND_CYC` falling edges.
- R8: An internal-oscillator target reached from source 0 holds `freqStable` at 0 for a further `STAB_CYC` output cycles after the handover.
- R9: An external or RC target needs no count beyond `HAND_CYC`, including when it is reached from source 0.
- R10: A write made during a handover is latched, with the latest write winning. It is carried out after the current handover completes, so `freqStable` rises once for each completed handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | NSRC | Free-running source clocks; bit 0 is the slow default source |
| rstN | input | 1 | Asynchronous active-low reset |
| selWrite | input | 1 | Write strobe for the select code and kind, synchronous to clkOut |
| selCode | input | $clog2(NSRC) | Requested source index |
| selKind | input | 2 | Kind of the requested source (0 internal, 1 crystal, 2 external/RC) |
| clkOut | output | 1 | Switched output clock |
| freqStable | output | 1 | High when the last handover, including any settling, is complete |

## Verification
The hardest case to reach is a second write landing inside an open handover. The write strobe is synchronous to the output clock, and that clock stops a few cycles after the first write. The bench therefore issues the second write on the output falling edge straight after the first one. At that point the old source is still passing through its synchronisers, so the write lands while the block is busy. The bench then counts the rising edges of the status flag and measures the final output period, which confirms that the held write ran last.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    KIND_INT  = 2'd0,
    KIND_XTAL = 2'd1,
    KIND_EXT  = 2'd2
  } srcKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic longStart;
  } handCfg_t;
endpackage

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned STAB_CYC = 4096,
  localparam int unsigned SEL_W   = $clog2(NSRC),
  localparam int unsigned STB_W   = $clog2(STAB_CYC + 1)
) (
  input  logic             clkOut,
  input  logic             rstN,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selCode,
  input  logic [1:0]       selKind,
  input  logic [NSRC-1:0]  enVec,
  output logic [SEL_W-1:0] reqSel,
  output logic [SEL_W-1:0] curSel,
  output handCfg_t         cfg,
  output logic             busy,
  output logic             freqStable
);
  typedef enum logic [1:0] {ST_IDLE, ST_HAND, ST_SETTLE} ctlState_e;

  ctlState_e        state;
  logic [1:0]       doneSync;
  logic             needSettle;
  logic             pendValid;
  logic [SEL_W-1:0] pendSel;
  logic [1:0]       pendKind;
  logic [STB_W-1:0] settleCnt;
  logic [SEL_W-1:0] nextSel;
  logic [1:0]       nextKind;

  assign nextSel  = selWrite ? selCode : pendSel;
  assign nextKind = selWrite ? selKind : pendKind;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clkOut or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      doneSync      <= '0;
      reqSel        <= '0;
      curSel        <= '0;
      cfg.longStart <= 1'b0;
      needSettle    <= 1'b0;
      pendValid     <= 1'b0;
      pendSel       <= '0;
      pendKind      <= '0;
      settleCnt     <= '0;
      freqStable    <= 1'b0;
    end else begin
      doneSync <= {doneSync[0], enVec[reqSel]};
      if (selWrite && busy) begin
        pendValid <= 1'b1;
        pendSel   <= selCode;
        pendKind  <= selKind;
      end
      unique case (state)
        ST_IDLE: begin
          if (selWrite || pendValid) begin
            pendValid <= 1'b0;
            if (nextSel != curSel) begin
              reqSel        <= nextSel;
              cfg.longStart <= (nextKind == KIND_XTAL) && (curSel == '0);
              needSettle    <= (nextKind == KIND_INT) && (curSel == '0);
              freqStable    <= 1'b0;
              doneSync      <= '0;
              state         <= ST_HAND;
            end
          end
        end
        ST_HAND: begin
          if (doneSync[1]) begin
            curSel <= reqSel;
            if (needSettle) begin
              settleCnt <= '0;
              state     <= ST_SETTLE;
            end else begin
              freqStable <= 1'b1;
              state      <= ST_IDLE;
            end
          end
        end
        ST_SETTLE: begin
          if (settleCnt == STB_W'(STAB_CYC - 1)) begin
            freqStable <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clksw_slice.sv
module clksw_slice
  import clksw_pkg::*;
#(
  parameter int unsigned IDX      = 0,
  parameter int unsigned HAND_CYC = 8,
  parameter int unsigned OST_CYC  = 1024,
  localparam int unsigned CNT_W   = $clog2(OST_CYC + 1)
) (
  input  logic     srcClk,
  input  logic     rstN,
  input  logic     want,
  input  logic     othersOff,
  input  handCfg_t cfg,
  output logic     en
);
  localparam logic RST_ON = (IDX == 0);

  logic [1:0]       wantSync;
  logic [1:0]       offSync;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = cfg.longStart ? CNT_W'(OST_CYC - 1) : CNT_W'(HAND_CYC - 1);

  // all state moves on the falling edge, so the gate only changes while this clock is low
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      wantSync <= {2{RST_ON}};
      offSync  <= {2{RST_ON}};
      cnt      <= '0;
      en       <= RST_ON;
    end else begin
      wantSync <= {wantSync[0], want};
      offSync  <= {offSync[0], othersOff};
      if (en) begin
        cnt <= '0;
        if (!wantSync[1]) en <= 1'b0;
      end else if (wantSync[1] && offSync[1]) begin
        if (cnt == lastCnt) begin
          en  <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/clksw_path.sv
module clksw_path
  import clksw_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned HAND_CYC = 8,
  parameter int unsigned OST_CYC  = 1024,
  localparam int unsigned SEL_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  srcClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] reqSel,
  input  handCfg_t         cfg,
  output logic [NSRC-1:0]  enVec,
  output logic             clkOut
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic want;
    logic othersOff;
    assign want      = (reqSel == SEL_W'(i));
    assign othersOff = ~|(enVec & ~(NSRC'(1) << i));
    clksw_slice #(
      .IDX(i), .HAND_CYC(HAND_CYC), .OST_CYC(OST_CYC)
    ) i_slice (
      .srcClk(srcClk[i]), .rstN(rstN), .want(want),
      .othersOff(othersOff), .cfg(cfg), .en(enVec[i])
    );
  end

  assign clkOut = |(srcClk & enVec);
endmodule

// File: rtl/clk_switcher.sv
module clk_switcher
  import clksw_pkg::*;
#(
  parameter int unsigned NSRC     = 4,
  parameter int unsigned HAND_CYC = 8,
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned STAB_CYC = 4096,
  localparam int unsigned SEL_W   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  srcClk,
  input  logic             rstN,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selCode,
  input  logic [1:0]       selKind,
  output logic             clkOut,
  output logic             freqStable
);
  logic [NSRC-1:0]  enVec;
  logic [SEL_W-1:0] reqSel;
  logic [SEL_W-1:0] curSel;
  logic             busy;
  handCfg_t         cfg;

  clksw_ctrl #(.NSRC(NSRC), .STAB_CYC(STAB_CYC)) i_ctrl (
    .clkOut(clkOut), .rstN(rstN), .selWrite(selWrite), .selCode(selCode),
    .selKind(selKind), .enVec(enVec), .reqSel(reqSel), .curSel(curSel),
    .cfg(cfg), .busy(busy), .freqStable(freqStable)
  );

  clksw_path #(.NSRC(NSRC), .HAND_CYC(HAND_CYC), .OST_CYC(OST_CYC)) i_path (
    .srcClk(srcClk), .rstN(rstN), .reqSel(reqSel), .cfg(cfg),
    .enVec(enVec), .clkOut(clkOut)
  );
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input logic             clkOut,
  input logic             rstN,
  input logic             selWrite,
  input logic [SEL_W-1:0] selCode,
  input logic [NSRC-1:0]  enVec,
  input logic [SEL_W-1:0] curSel,
  input logic             busy,
  input logic             freqStable
);
  // R2
  start_clears_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    (!busy && selWrite && selCode != curSel) |=> !freqStable);

  // R3
  same_ignored_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    (!busy && selWrite && selCode == curSel) |=> ($stable(freqStable) && $stable(curSel) && !busy));

  // R4
  single_gate_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    $onehot0(enVec));

  // R5
  busy_not_stable_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    busy |-> !freqStable);

  // R5
  stable_on_new_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    $rose(freqStable) |-> enVec[curSel]);
endmodule

bind clk_switcher clksw_chk #(.NSRC(NSRC)) i_chk (
  .clkOut(clkOut), .rstN(rstN), .selWrite(selWrite), .selCode(selCode),
  .enVec(enVec), .curSel(curSel), .busy(busy), .freqStable(freqStable)
);

// File: tb/test_clk_switcher.sv
`timescale 1ns/1ps
module test_clk_switcher;
  localparam int NSRC = 4;
  localparam int HAND = 8;
  localparam int OST  = 1024;
  localparam int STAB = 200;
  localparam int NVEC = 7;
  localparam real PER [NSRC] = '{40.0, 4.0, 10.0, 16.0};

  // sel, kind, expected period, min ns write->stable, max ns (0 = none)
  localparam int VEC [NVEC][5] = '{
    '{2, 0, 10, 2000, 0},
    '{3, 1, 16, 128, 740},
    '{0, 0, 40, 320, 1760},
    '{3, 1, 16, 16384, 0},
    '{0, 0, 40, 320, 1760},
    '{1, 2, 4, 32, 560},
    '{2, 0, 10, 80, 440}
  };
  localparam string TAG [NVEC] = '{"R8", "R7", "R5", "R6", "R5", "R9", "R5"};

  logic [NSRC-1:0] srcClk = '0;
  logic rstN = 1'b0;
  logic selWrite = 1'b0;
  logic [1:0] selCode = '0;
  logic [1:0] selKind = '0;
  logic clkOut;
  logic freqStable;

  int nChk = 0;
  int nFail = 0;
  int riseCnt = 0;
  realtime lastEdge = 0.0;
  realtime minWidth = 1.0e9;
  realtime maxLow = 0.0;
  realtime w;

  clk_switcher #(.NSRC(NSRC), .HAND_CYC(HAND), .OST_CYC(OST), .STAB_CYC(STAB)) i_clk_switcher (
    .srcClk(srcClk), .rstN(rstN), .selWrite(selWrite), .selCode(selCode),
    .selKind(selKind), .clkOut(clkOut), .freqStable(freqStable)
  );

  always #20 srcClk[0] = ~srcClk[0];
  always #2  srcClk[1] = ~srcClk[1];
  always #5  srcClk[2] = ~srcClk[2];
  always #8  srcClk[3] = ~srcClk[3];

  always @(clkOut) begin
    if (rstN) begin
      w = $realtime - lastEdge;
      if (w < minWidth) minWidth = w;
      if (clkOut && w > maxLow) maxLow = w;
    end
    lastEdge = $realtime;
  end

  always @(posedge freqStable) riseCnt++;

  task automatic check(input bit ok, input string req, input real act, input real exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic measPeriod(output real p);
    realtime t0;
    @(posedge clkOut); t0 = $realtime;
    @(posedge clkOut); p = $realtime - t0;
  endtask

  task automatic waitStable();
    for (int n = 0; n < 60000 && !freqStable; n++) @(posedge srcClk[1]);
  endtask

  initial begin
    #(200000 * 4);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    real p;
    realtime tStart;
    #103 rstN = 1'b1;
    #7;
    check(freqStable == 1'b0, "R1 stable after reset", real'(freqStable), 0.0);
    measPeriod(p);
    check(p > 39.99 && p < 40.01, "R1 default source period", p, 40.0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clkOut);
      maxLow = 0.0;
      tStart = $realtime;
      selWrite = 1'b1; selCode = 2'(VEC[v][0]); selKind = 2'(VEC[v][1]);
      @(negedge clkOut);
      selWrite = 1'b0;
      check(freqStable == 1'b0, "R2 stable cleared by write", real'(freqStable), 0.0);
      waitStable();
      w = $realtime - tStart;
      check(w >= real'(VEC[v][3]) && (VEC[v][4] == 0 || w <= real'(VEC[v][4])),
            {TAG[v], " handover time"}, w, real'(VEC[v][3]));
      measPeriod(p);
      check(p > real'(VEC[v][2]) - 0.01 && p < real'(VEC[v][2]) + 0.01,
            {TAG[v], " new period"}, p, real'(VEC[v][2]));
      check(maxLow >= HAND * PER[VEC[v][0]], "R4 parked low span", maxLow, HAND * PER[VEC[v][0]]);
    end

    // R3: same code while idle
    @(negedge clkOut);
    selWrite = 1'b1; selCode = 2'd2; selKind = 2'd0;
    @(negedge clkOut);
    selWrite = 1'b0;
    repeat (100) @(negedge clkOut);
    check(freqStable == 1'b1, "R3 stable kept", real'(freqStable), 1.0);
    measPeriod(p);
    check(p > 9.99 && p < 10.01, "R3 source kept", p, 10.0);

    // R10: second write while busy
    riseCnt = 0;
    @(negedge clkOut);
    selWrite = 1'b1; selCode = 2'd0; selKind = 2'd0;
    @(negedge clkOut);
    selCode = 2'd3; selKind = 2'd2;
    @(negedge clkOut);
    selWrite = 1'b0;
    for (int n = 0; n < 60000 && !(freqStable && riseCnt >= 2); n++) @(posedge srcClk[1]);
    check(riseCnt == 2, "R10 two completions", real'(riseCnt), 2.0);
    measPeriod(p);
    check(p > 15.99 && p < 16.01, "R10 latched target period", p, 16.0);

    check(minWidth >= 1.99, "R4 no short pulse", minWidth, 2.0);
    summary();
  end
endmodule